// File: doc/BRIEF.md
# Address-Shared GPIO Port Controller

This block runs a four-pin general-purpose I/O port whose pins can be lent to the external bus as upper address lines. Software controls the port through a small register bus. A write-only direction register, an output data register, a pull-up enable register and an open-drain select register hold the configuration. A read-only pin view returns the pin levels. The block drives per-pin output-enable, output-value and pull-up-enable signals toward pad models, and takes the pad input levels back through a two-stage synchronizer.

Two plain control inputs come from outside the port. The first is a per-pin address-enable vector supplied by the chip's function-control logic. The second is the operating mode. In the expanded modes 4, 5 and 6, any pin whose address-enable bit is set carries the matching address bit, whatever its direction bit says. In every other mode the address-enable bits have no effect.

Hardware standby forces every pad quiet and clears the direction register. Software standby keeps the register state. In software standby, the address-output pins either hold their last driven level or release the line, as an output-hold input selects.

The register bus has no back-pressure. A write completes at the clock edge where it is presented. A read presented at an edge returns its data together with a one-cycle valid pulse just after that edge. There is no ready signal, so the bus must accept read data in that cycle.

Top module: `addr_port_ctl`

## Requirements
- R1: After reset, the data, pull-up, open-drain and direction registers are all zero. While no pin is taken by address, every pad_oe and every pad_pu bit is 0.
- R2: A read at the direction address (0xFE39) returns the fill value 0xFF, never the stored bits. In every other register read, bits 7..4 read as 1 from the same fill value.
- R3: A pin that is not taken by address is an output when its direction bit is 1 (pad_oe=1, pad_out equal to its data bit). It is an input when its direction bit is 0 (pad_oe=0). pad_out is 0 whenever pad_oe is 0.
- R4: When op_mode is 4, 5 or 6, a pin with addr_en set has pad_oe=1 and pad_out equal to its addr_bits bit, whatever its direction and data bits hold. For any other op_mode value, addr_en is ignored.
- R5: A read at the pin address (0xFFB9) returns the data bit for pins that are general outputs. For all other pins it returns pad_in after two synchronizer stages.
- R6: For a general-output pin whose open-drain bit is set, a data bit of 1 gives pad_oe=0 and a data bit of 0 gives pad_oe=1 with pad_out=0. Address pins ignore the open-drain bit.
- R7: pad_pu is 1 only for a pin that is a general input with its pull-up bit set. It is never 1 together with pad_oe.
- R8: While hw_stby is high, all pad_oe and pad_pu bits are 0, bus writes are ignored, and the direction register is cleared. The data, pull-up and open-drain registers keep their values.
- R9: While sw_stby is high, the register contents are kept and general-I/O pins behave as before. Address pins drive the addr_bits value sampled on the last edge before entry when hold_out is 1, and go high-impedance (pad_oe=0) when hold_out is 0.
- R10: Registers decode at data 0xFF09, pull-up 0xFF40 and open-drain 0xFF47. A read returns bus_rvalid=1 for exactly the cycle after the read edge. Writes to the pin address or to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | Operating mode; 4..6 allow address takeover |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| hold_out | input | 1 | In software standby, 1 holds address pins, 0 releases them |
| addr_en | input | 4 | Per-pin address-enable bits from function control |
| addr_bits | input | 4 | Address bits to drive on taken pins |
| pad_in | input | 4 | Pad input levels (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-data valid |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output value |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
Several per-pin rules are checked by the assertions on every cycle:
- address pins drive their address bit outside standby;
- pull-up and output enable never coincide;
- a released output drives 0;
- a disabled open-drain high pin is off;
- hardware standby is quiet and clears the direction register;
- the held address value stays frozen through software standby;
- writes to the pin view change nothing.

The bench's scenarios cover what needs history or a register read:
- the direction register never reads back;
- the synchronized pin view follows the pads;
- the direction state survives software standby but is gone after hardware standby;
- each combination of mode, address enable, direction, data, open-drain and pull-up bits produces the expected pad signals.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  // Role a pin plays in the current cycle
  typedef enum logic [1:0] {
    PIN_IN   = 2'd0,
    PIN_GPO  = 2'd1,
    PIN_ADDR = 2'd2,
    PIN_OFF  = 2'd3
  } pin_role_e;

  localparam int BUS_DW = 8;
  localparam int MODE_W = 3;
endpackage

// File: rtl/gpa_sync.sv
module gpa_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpa_regs.sv
module gpa_regs #(
  parameter int             NPINS = 4,
  parameter int             AW    = 16,
  parameter logic [AW-1:0]  A_DIR = 16'hFE39,
  parameter logic [AW-1:0]  A_DAT = 16'hFF09,
  parameter logic [AW-1:0]  A_PIN = 16'hFFB9,
  parameter logic [AW-1:0]  A_PU  = 16'hFF40,
  parameter logic [AW-1:0]  A_OD  = 16'hFF47,
  parameter logic [7:0]     FILL  = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic [NPINS-1:0] pin_view,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] dat_o,
  output logic [NPINS-1:0] pu_o,
  output logic [NPINS-1:0] od_o,
  output logic [7:0]       rdata,
  output logic             rvalid
);
  logic [NPINS-1:0] dir_q, dat_q, pu_q, od_q;
  logic [7:0]       rd_mux;
  logic             wr_ok;
  logic             unused_wr_hi;

  assign unused_wr_hi = &{1'b0, bus_wdata[7:NPINS]};
  assign wr_ok        = bus_wr && !hw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dat_q  <= '0;
      pu_q   <= '0;
      od_q   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (hw_stby) dir_q <= '0;
      else if (wr_ok && bus_addr == A_DIR) dir_q <= bus_wdata[NPINS-1:0];
      if (wr_ok && bus_addr == A_DAT) dat_q <= bus_wdata[NPINS-1:0];
      if (wr_ok && bus_addr == A_PU)  pu_q  <= bus_wdata[NPINS-1:0];
      if (wr_ok && bus_addr == A_OD)  od_q  <= bus_wdata[NPINS-1:0];
      rvalid <= bus_rd;
      if (bus_rd) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = FILL;
    if (bus_addr == A_DIR)      rd_mux = FILL;
    else if (bus_addr == A_DAT) rd_mux[NPINS-1:0] = dat_q;
    else if (bus_addr == A_PIN) rd_mux[NPINS-1:0] = pin_view;
    else if (bus_addr == A_PU)  rd_mux[NPINS-1:0] = pu_q;
    else if (bus_addr == A_OD)  rd_mux[NPINS-1:0] = od_q;
    else                        rd_mux = '0;
  end

  assign dir_o = dir_q;
  assign dat_o = dat_q;
  assign pu_o  = pu_q;
  assign od_o  = od_q;

  assert_dir_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0));
  assert_dat_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> $stable({dat_q, pu_q, od_q}));
  assert_pin_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PIN && !hw_stby) |=> $stable({dir_q, dat_q, pu_q, od_q}));
  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rvalid);
endmodule

// File: rtl/gpa_pin.sv
module gpa_pin
  import gpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exp_mode,
  input  logic aen,
  input  logic abit,
  input  logic aheld,
  input  logic dir,
  input  logic dat,
  input  logic pu,
  input  logic od,
  input  logic hw_stby,
  input  logic sw_stby,
  input  logic hold_out,
  output logic oe,
  output logic out,
  output logic pue,
  output logic is_gpo
);
  pin_role_e role;

  always_comb begin
    if (hw_stby)             role = PIN_OFF;
    else if (exp_mode && aen) role = PIN_ADDR;
    else if (dir)            role = PIN_GPO;
    else                     role = PIN_IN;
  end

  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    pue = 1'b0;
    unique case (role)
      PIN_ADDR: begin
        oe  = sw_stby ? hold_out : 1'b1;
        out = sw_stby ? (hold_out & aheld) : abit;
      end
      PIN_GPO: begin
        oe  = !(od && dat);
        out = dat && !od;
      end
      PIN_IN:  pue = pu;
      default: ;
    endcase
  end

  assign is_gpo = (role == PIN_GPO);

  assert_addr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_mode && aen && !hw_stby && !sw_stby) |-> (oe && out == abit));
  assert_pu_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pue && oe));
  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !out);
  assert_od_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && od && dat && !(exp_mode && aen) && !hw_stby) |-> !oe);
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (!oe && !pue));
endmodule

// File: rtl/addr_port_ctl.sv
module addr_port_ctl
  import gpa_pkg::*;
#(
  parameter int            NPINS   = 4,
  parameter int            AW      = 16,
  parameter int            EXP_LO  = 4,
  parameter int            EXP_HI  = 6,
  parameter int            SYNC_N  = 2,
  parameter logic [AW-1:0] A_DIR   = 16'hFE39,
  parameter logic [AW-1:0] A_DAT   = 16'hFF09,
  parameter logic [AW-1:0] A_PIN   = 16'hFFB9,
  parameter logic [AW-1:0] A_PU    = 16'hFF40,
  parameter logic [AW-1:0] A_OD    = 16'hFF47,
  parameter logic [7:0]    FILL    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              hold_out,
  input  logic [NPINS-1:0]  addr_en,
  input  logic [NPINS-1:0]  addr_bits,
  input  logic [NPINS-1:0]  pad_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu
);
  localparam logic [MODE_W-1:0] M_LO = MODE_W'(EXP_LO);
  localparam logic [MODE_W-1:0] M_HI = MODE_W'(EXP_HI);

  logic [NPINS-1:0] dir_v, dat_v, pu_v, od_v;
  logic [NPINS-1:0] pin_sync, gpo_v, pin_view, held_q;
  logic             exp_mode;

  assign exp_mode = (op_mode >= M_LO) && (op_mode <= M_HI);

  // Last address value seen outside software standby
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        held_q <= '0;
    else if (!sw_stby) held_q <= addr_bits;

  gpa_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  assign pin_view = (gpo_v & dat_v) | (~gpo_v & pin_sync);

  gpa_regs #(
    .NPINS(NPINS), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PIN(A_PIN),
    .A_PU(A_PU), .A_OD(A_OD), .FILL(FILL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pin_view(pin_view), .dir_o(dir_v), .dat_o(dat_v), .pu_o(pu_v),
    .od_o(od_v), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpa_pin u_pin (
        .clk(clk), .rst_n(rst_n), .exp_mode(exp_mode), .aen(addr_en[i]),
        .abit(addr_bits[i]), .aheld(held_q[i]), .dir(dir_v[i]),
        .dat(dat_v[i]), .pu(pu_v[i]), .od(od_v[i]), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .hold_out(hold_out), .oe(pad_oe[i]),
        .out(pad_out[i]), .pue(pad_pu[i]), .is_gpo(gpo_v[i])
      );
    end
  endgenerate

  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && $past(sw_stby)) |-> $stable(held_q));
  assert_no_addr_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_mode && !hw_stby) |-> ((pad_oe & ~dir_v) == '0));
endmodule

// File: tb/addr_port_ctl_test.sv
module addr_port_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_mode = 3'd0;
  logic        hw_stby = 1'b0, sw_stby = 1'b0, hold_out = 1'b0;
  logic [3:0]  addr_en = '0, addr_bits = '0, pad_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  pad_oe, pad_out, pad_pu;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  localparam logic [15:0] A_DIR = 16'hFE39, A_DAT = 16'hFF09, A_PIN = 16'hFFB9,
                          A_PU = 16'hFF40, A_OD = 16'hFF47;

  addr_port_ctl uut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .hold_out(hold_out), .addr_en(addr_en),
    .addr_bits(addr_bits), .pad_in(pad_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      report();
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  initial begin
    logic [7:0] d;
    logic       v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pad_oe, 0);
    chk("R1 pu", pad_pu, 0);
    rd(A_DAT, d, v); chk("R1 dat", d, 8'hF0); chk("R10 rvalid", v, 1);
    rd(A_PU, d, v);  chk("R1 pu reg", d, 8'hF0);
    rd(A_OD, d, v);  chk("R1 od reg", d, 8'hF0);
    @(negedge clk);  chk("R10 rvalid idle", bus_rvalid, 0);

    // R2 direction is write-only
    wr(A_DIR, 8'h0A);
    rd(A_DIR, d, v); chk("R2 dir read", d, 8'hFF);
    chk("R1 R3 dir took effect", pad_oe, 4'hA);

    // R3 sweep of direction and data
    for (int dr = 0; dr < 16; dr++)
      for (int dt = 0; dt < 16; dt++) begin
        wr(A_DIR, 8'(dr)); wr(A_DAT, 8'(dt));
        chk("R3 oe", pad_oe, dr);
        chk("R3 out", pad_out, dr & dt);
      end

    // R6 open-drain sweep, all outputs
    wr(A_DIR, 8'h0F);
    for (int o = 0; o < 16; o++)
      for (int dt = 0; dt < 16; dt++) begin
        wr(A_OD, 8'(o)); wr(A_DAT, 8'(dt));
        chk("R6 oe", pad_oe, ~(o & dt) & 4'hF);
        chk("R6 out", pad_out, dt & ~o & 4'hF);
      end
    wr(A_OD, 8'h00);

    // R7 pull-up sweep
    for (int dr = 0; dr < 16; dr++)
      for (int p = 0; p < 16; p++) begin
        wr(A_DIR, 8'(dr)); wr(A_PU, 8'(p));
        chk("R7 pu", pad_pu, p & ~dr & 4'hF);
      end

    // R4 mode / address-enable sweep
    wr(A_DIR, 8'h05); wr(A_DAT, 8'h0F); wr(A_PU, 8'h0F); wr(A_OD, 8'h0F);
    addr_bits = 4'hA;
    for (int m = 0; m < 8; m++)
      for (int ae = 0; ae < 16; ae++) begin
        int am;
        @(negedge clk);
        op_mode = 3'(m); addr_en = 4'(ae);
        #2;
        am = (m >= 4 && m <= 6) ? ae : 0;
        // od set and data 1: general outputs are released
        chk("R4 oe", pad_oe, am);
        chk("R4 out", pad_out, am & 4'hA);
        chk("R4 R7 pu", pad_pu, ~am & ~5 & 4'hF);
      end
    op_mode = 3'd0; addr_en = '0; wr(A_OD, 8'h00); wr(A_PU, 8'h00);

    // R5 pin view
    wr(A_DIR, 8'h03); wr(A_DAT, 8'h01);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); pad_in = 4'(p);
      repeat (3) @(negedge clk);
      rd(A_PIN, d, v);
      chk("R5 pin view", d, 8'hF0 | 1 | (p & 4'hC));
    end

    // R10 writes to pin view and unmapped address are ignored
    wr(A_PIN, 8'h0E); wr(16'hFF0A, 8'h0E);
    rd(A_DAT, d, v); chk("R10 dat unchanged", d, 8'hF1);
    chk("R10 dir unchanged", pad_oe, 4'h3);
    rd(16'h1234, d, v); chk("R10 unmapped read", d, 8'h00);

    // R9 software standby
    wr(A_DAT, 8'h02); op_mode = 3'd4; addr_en = 4'hC; addr_bits = 4'h8;
    hold_out = 1'b1;
    @(negedge clk); sw_stby = 1'b1;
    @(negedge clk); addr_bits = 4'h4; #2;
    chk("R9 hold oe", pad_oe, 4'hF);
    chk("R9 hold out", pad_out, 4'hA);
    hold_out = 1'b0; #1;
    chk("R9 release oe", pad_oe, 4'h3);
    chk("R9 release out", pad_out, 4'h2);
    @(negedge clk); sw_stby = 1'b0; #1;
    chk("R9 exit out", pad_out, 4'h6);
    chk("R9 dir kept", pad_oe, 4'hF);
    op_mode = 3'd0; addr_en = '0;

    // R8 hardware standby
    wr(A_DIR, 8'h0F); wr(A_DAT, 8'h0F); wr(A_PU, 8'h0F);
    @(negedge clk); hw_stby = 1'b1; #1;
    chk("R8 oe quiet", pad_oe, 0);
    chk("R8 pu quiet", pad_pu, 0);
    wr(A_DAT, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    @(negedge clk);
    chk("R8 dir cleared", pad_oe, 0);
    chk("R8 pu kept", pad_pu, 4'hF);
    rd(A_DAT, d, v); chk("R8 dat kept", d, 8'hFF);

    done = 1;
    report();
  end
endmodule